// File: doc/BRIEF.md
# Byte-Write Memory Host Controller with Completion Polling

This block is a bus master for a byte-wide nonvolatile memory that is accessed like an asynchronous static RAM: a 13-bit address, an 8-bit data path split into separate drive, enable and sample wires, and active-low chip select, output enable and write strobe. A requester hands it one command at a time over a valid/ready port. For a read, the block runs one timed read cycle and returns the byte. For a write, it runs one timed write strobe. It then waits for the memory's self-timed internal write to finish and only then returns a response.

Pin timing comes from a single down-counter. Every delay is given in nanoseconds and converted to whole clock cycles by rounding up against a clock-period parameter. Write completion is found in one of two ways, selected for each request. In the first, the block rereads the written address until the top data bit shows the value that was written; while the write is still in progress, the memory returns the complement of that bit. In the second, the block watches a shared open-drain ready/busy line through a synchronizer. In both cases a cycle bound ends the wait and reports an error.

Top module: `nvm_host_ctrl`

## Requirements
- R1: A read holds chip select and output enable low with the write strobe high for ceil(max(tACC,tCE,tOE)/period) cycles. The data input is sampled on the last of those cycles and returned on `rsp_rdata_o`.
- R2: Once output enable rises after a read, the block leaves the data bus undriven for at least ceil(tDF/period) cycles. It never drives the bus while output enable is low.
- R3: A write drives the write strobe low with chip select low and output enable high. The strobe stays low for ceil(tWP/period) cycles. Address and data are stable from one cycle before the falling edge of the strobe, and data stays driven for ceil(tDH/period) cycles after the rising edge.
- R4: With `mode_rdy_i`=0 at acceptance, a write is followed by repeated full read cycles of the same address. The write completes when data bit 7 of such a read equals bit 7 of the written byte.
- R5: With `mode_rdy_i`=1 at acceptance, no read is issued after the write. After BUSY_LAT_CYC blind cycles, the write completes when the synchronized `mem_rdy_i` is high (low means busy). Bit 7 of the data input is ignored.
- R6: From the acceptance of a write until its response, `req_ready_o` stays low and no other access starts.
- R7: If completion has not been seen TIMEOUT_CYC cycles after the write strobe sequence ends, the write is answered with `rsp_err_o`=1.
- R8: Every command gets exactly one response: a one-cycle pulse on `rsp_valid_o`. `rsp_err_o` is 0 for reads and for completed writes, and `rsp_rdata_o` is 0 for writes.
- R9: A command is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while idle. The command fields and `mode_rdy_i` are captured at that edge.
- R10: After reset, chip select, output enable and write strobe are high, the bus is not driven, `req_ready_o` is high and `rsp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command valid |
| req_ready_o | output | 1 | Command accepted when high together with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Byte address |
| req_wdata_i | input | 8 | Write data |
| mode_rdy_i | input | 1 | Completion method: 1 = ready/busy line, 0 = bit-7 polling |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_rdata_o | output | 8 | Read data (0 for writes) |
| rsp_err_o | output | 1 | Write completion timed out |
| mem_addr_o | output | 13 | Memory address pins |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_dq_o | output | 8 | Data to memory |
| mem_dq_oe_o | output | 1 | Data drive enable |
| mem_dq_i | input | 8 | Data from memory |
| mem_rdy_i | input | 1 | Shared ready/busy line, pulled up externally |

## Verification
The assertions assume that `mem_rdy_i` reads high whenever no write is in progress, which requires a pull-up on the open-drain line. They also assume that the memory pulls it low within BUSY_LAT_CYC cycles of the write strobe rising. The bench's responder starts its busy period on the same cycle it sees the strobe rise, and it releases the line only when the model's write ends. The assertions further assume that the requester does not change fields outside acceptance in a way that matters. The bench drives a command only on a falling edge at which ready is high, and it drops valid one cycle later. The timeout bound must exceed the memory's write time. The bench keeps the normal busy period well below TIMEOUT_CYC and exceeds it only in the tests that are meant to time out.

// File: rtl/nvm_host_pkg.sv
package nvm_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_FLT,
    ST_WR_SET,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_VF_WAIT,
    ST_RSP
  } nvm_state_e;

  // ns -> whole cycles, rounded up, never zero
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  // load N -> expired on the Nth cycle of the state being entered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_load_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i != '0));

endmodule

// File: rtl/nvm_rdy_sync.sv
module nvm_rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  output logic rdy_o
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= rdy_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= {sh_q[STAGES-2:0], rdy_i};
      end
    end
  endgenerate

  assign rdy_o = sh_q[STAGES-1];

endmodule

// File: rtl/nvm_wr_verify.sv
module nvm_wr_verify #(
  parameter int unsigned TIMEOUT_CYC = 120000,
  localparam int unsigned TO_W = $clog2(TIMEOUT_CYC + 1) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic clear_i,
  input  logic rdy_mode_i,
  input  logic rdy_sync_i,
  input  logic poll_sample_i,
  input  logic poll_bit_i,
  input  logic expect_bit_i,
  output logic done_o,
  output logic timeout_o
);

  logic            armed_q;
  logic            poll_ok_q;
  logic [TO_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      poll_ok_q <= 1'b0;
      age_q     <= '0;
    end else if (arm_i) begin
      armed_q   <= 1'b1;
      poll_ok_q <= 1'b0;
      age_q     <= '0;
    end else if (clear_i) begin
      armed_q   <= 1'b0;
    end else if (armed_q) begin
      if (age_q < TO_W'(TIMEOUT_CYC)) age_q <= age_q + 1'b1;
      if (poll_sample_i && (poll_bit_i == expect_bit_i)) poll_ok_q <= 1'b1;
    end
  end

  assign done_o    = armed_q && (rdy_mode_i ? rdy_sync_i : poll_ok_q);
  assign timeout_o = armed_q && (age_q >= TO_W'(TIMEOUT_CYC));

  // a poll sample only arrives while a write is being verified
  p_poll_armed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_sample_i |-> (armed_q && !rdy_mode_i));

endmodule

// File: rtl/nvm_host_ctrl.sv
module nvm_host_ctrl
  import nvm_host_pkg::*;
#(
  parameter int unsigned AW            = 13,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_ACC_NS      = 250,
  parameter int unsigned T_CE_NS       = 250,
  parameter int unsigned T_OE_NS       = 100,
  parameter int unsigned T_DF_NS       = 60,
  parameter int unsigned T_WP_NS       = 100,
  parameter int unsigned T_DH_NS       = 10,
  parameter int unsigned BUSY_LAT_CYC  = 4,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned TIMEOUT_CYC   = 120000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          mode_rdy_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_err_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i,
  input  logic          mem_rdy_i
);

  localparam int unsigned N_RD  = ns_to_cyc(max2(T_ACC_NS, max2(T_CE_NS, T_OE_NS)), CLK_PERIOD_NS);
  localparam int unsigned N_DF  = ns_to_cyc(T_DF_NS, CLK_PERIOD_NS);
  localparam int unsigned N_WP  = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
  localparam int unsigned N_DH  = ns_to_cyc(T_DH_NS, CLK_PERIOD_NS);
  localparam int unsigned N_LAT = (BUSY_LAT_CYC == 0) ? 1 : BUSY_LAT_CYC;
  localparam int unsigned N_MAX = max2(max2(N_RD, N_DF), max2(max2(N_WP, N_DH), N_LAT));
  localparam int unsigned TW    = $clog2(N_MAX + 1) + 1;

  nvm_state_e state_q, state_d;

  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          take, to_poll, rd_capture, err_set;
  logic          vf_arm, vf_clear, vf_sample, vf_done, vf_timeout;
  logic          rdy_sync;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          write_q, mode_q, poll_q, err_q;
  logic          ce_n_q, oe_n_q, we_n_q, dq_oe_q;

  nvm_cycle_timer #(.W(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  nvm_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rdy_i  (mem_rdy_i),
    .rdy_o  (rdy_sync)
  );

  nvm_wr_verify #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_vf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .arm_i         (vf_arm),
    .clear_i       (vf_clear),
    .rdy_mode_i    (mode_q),
    .rdy_sync_i    (rdy_sync),
    .poll_sample_i (vf_sample),
    .poll_bit_i    (mem_dq_i[DW-1]),
    .expect_bit_i  (wdata_q[DW-1]),
    .done_o        (vf_done),
    .timeout_o     (vf_timeout)
  );

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = TW'(1);
    take       = 1'b0;
    to_poll    = 1'b0;
    rd_capture = 1'b0;
    err_set    = 1'b0;
    vf_arm     = 1'b0;
    vf_clear   = 1'b0;
    vf_sample  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        take     = 1'b1;
        tmr_load = 1'b1;
        if (req_write_i) begin
          state_d = ST_WR_SET;
          tmr_val = TW'(1);
        end else begin
          state_d = ST_RD_ACC;
          tmr_val = TW'(N_RD);
        end
      end
      ST_RD_ACC: if (tmr_exp) begin
        state_d    = ST_RD_FLT;
        tmr_load   = 1'b1;
        tmr_val    = TW'(N_DF);
        vf_sample  = poll_q;
        rd_capture = !poll_q;
      end
      ST_RD_FLT: if (tmr_exp) begin
        if (!poll_q || vf_done) begin
          state_d = ST_RSP;
        end else if (vf_timeout) begin
          state_d = ST_RSP;
          err_set = 1'b1;
        end else begin
          state_d  = ST_RD_ACC;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_RD);
        end
      end
      ST_WR_SET: if (tmr_exp) begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = TW'(N_WP);
      end
      ST_WR_PULSE: if (tmr_exp) begin
        state_d  = ST_WR_HOLD;
        tmr_load = 1'b1;
        tmr_val  = TW'(N_DH);
      end
      ST_WR_HOLD: if (tmr_exp) begin
        vf_arm   = 1'b1;
        tmr_load = 1'b1;
        if (mode_q) begin
          state_d = ST_VF_WAIT;
          tmr_val = TW'(N_LAT);
        end else begin
          state_d = ST_RD_ACC;
          tmr_val = TW'(N_RD);
          to_poll = 1'b1;
        end
      end
      ST_VF_WAIT: begin
        if (tmr_exp && vf_done) begin
          state_d = ST_RSP;
        end else if (vf_timeout) begin
          state_d = ST_RSP;
          err_set = 1'b1;
        end
      end
      ST_RSP: begin
        state_d  = ST_IDLE;
        vf_clear = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      write_q <= 1'b0;
      mode_q  <= 1'b0;
      poll_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        write_q <= req_write_i;
        mode_q  <= mode_rdy_i;
        poll_q  <= 1'b0;
        err_q   <= 1'b0;
      end
      if (to_poll)    poll_q  <= 1'b1;
      if (rd_capture) rdata_q <= mem_dq_i;
      if (err_set)    err_q   <= 1'b1;
    end
  end

  // pins registered from next state: glitch-free strobes aligned with state_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      ce_n_q  <= !(state_d inside {ST_RD_ACC, ST_WR_SET, ST_WR_PULSE, ST_WR_HOLD});
      oe_n_q  <= !(state_d == ST_RD_ACC);
      we_n_q  <= !(state_d == ST_WR_PULSE);
      dq_oe_q <= state_d inside {ST_WR_SET, ST_WR_PULSE, ST_WR_HOLD};
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_rdata_o = write_q ? '0 : rdata_q;
  assign rsp_err_o   = err_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_ce_no   = ce_n_q;
  assign mem_oe_no   = oe_n_q;
  assign mem_we_no   = we_n_q;
  assign mem_dq_oe_o = dq_oe_q;

  p_read_ctrl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (mem_we_no && !mem_ce_no));

  p_no_drive_oe_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  p_release_after_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> !mem_dq_oe_o);

  p_we_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no && mem_dq_oe_o));

  p_we_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && !mem_ce_no));

  p_idle_no_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && !mem_dq_oe_o));

  p_rsp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_err_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> write_q);

endmodule

// File: tb/sim_nvm_host_ctrl.sv
module sim_nvm_host_ctrl;

  localparam int unsigned CLK_NS    = 10;
  localparam int unsigned ACC_CYC   = 12;   // 120 ns
  localparam int unsigned DF_CYC    = 5;    // 45 ns
  localparam int unsigned WP_CYC    = 10;   // 100 ns
  localparam int unsigned LAT_CYC   = 4;
  localparam int unsigned TO_CYC    = 400;
  localparam int unsigned BUSY_NORM = 60;
  localparam int unsigned NVEC      = 11;

  // [31] write, [30] ready/busy mode, [28:16] addr, [15:8] wdata, [7:0] expected read data
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 13'h0010, 8'hA5, 8'h00},
    {1'b0, 1'b0, 1'b0, 13'h0010, 8'h00, 8'hA5},
    {1'b1, 1'b1, 1'b0, 13'h1FFF, 8'h3C, 8'h00},
    {1'b0, 1'b0, 1'b0, 13'h1FFF, 8'h00, 8'h3C},
    {1'b1, 1'b0, 1'b0, 13'h0000, 8'h7E, 8'h00},
    {1'b0, 1'b0, 1'b0, 13'h0000, 8'h00, 8'h7E},
    {1'b1, 1'b1, 1'b0, 13'h0010, 8'h81, 8'h00},
    {1'b0, 1'b0, 1'b0, 13'h0010, 8'h00, 8'h81},
    {1'b0, 1'b0, 1'b0, 13'h0123, 8'h00, 8'hFF},
    {1'b1, 1'b0, 1'b0, 13'h1000, 8'h80, 8'h00},
    {1'b0, 1'b0, 1'b0, 13'h1000, 8'h00, 8'h80}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, mode_rdy = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [7:0]  rsp_rdata;
  logic [12:0] mem_addr;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = 8'h00;
  logic        rdy = 1'b1;

  int checks = 0, failures = 0, cyc = 0;

  // responder state
  logic [7:0]  mem [int];
  int          age = 0, since_off = 1000, busy_left = 0, busy_len = BUSY_NORM;
  int          we_low = 0, poll_reads = 0;
  logic        prev_we = 1'b1, prev_oe = 1'b1, prev_dq_oe = 1'b0;
  logic        poll_lie = 1'b0, rdy_stuck_low = 1'b0;
  logic [12:0] fall_addr = '0, wr_addr = '0;
  logic [7:0]  fall_data = '0, wr_data = '0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvm_host_ctrl #(
    .CLK_PERIOD_NS(CLK_NS), .T_ACC_NS(120), .T_CE_NS(120), .T_OE_NS(60),
    .T_DF_NS(45), .T_WP_NS(100), .T_DH_NS(10), .BUSY_LAT_CYC(LAT_CYC),
    .TIMEOUT_CYC(TO_CYC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .mode_rdy_i(mode_rdy),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .mem_addr_o(mem_addr), .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i), .mem_rdy_i(rdy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  // behavioural memory: access delay, float, self-timed write, bit-7 polling, ready/busy
  always @(negedge clk) begin
    logic [7:0] truth;
    if (busy_left > 0) begin
      busy_left = busy_left - 1;
      if (busy_left == 0) mem[int'(wr_addr)] = wr_data;
    end
    if (!ce_n && !oe_n && we_n) begin
      age = age + 1;
      since_off = 0;
    end else begin
      age = 0;
      if (since_off < 1000) since_off = since_off + 1;
    end
    if (prev_oe && !oe_n && busy_left > 0) begin
      poll_reads = poll_reads + 1;
      check(mem_addr == wr_addr, "R4 poll address", int'(mem_addr), int'(wr_addr));
    end
    if (dq_oe && !prev_dq_oe)
      check(since_off > DF_CYC, "R2 float before drive", since_off, DF_CYC + 1);
    if (dq_oe && !oe_n) check(1'b0, "R2 contention", 1, 0);
    if (!we_n) we_low = we_low + 1;
    if (prev_we && !we_n) begin
      check(!ce_n && oe_n && dq_oe, "R3 strobe controls", {ce_n, oe_n, dq_oe}, 3'b011);
      fall_addr = mem_addr;
      fall_data = dq_o;
    end
    if (!prev_we && we_n) begin
      check(we_low >= WP_CYC, "R3 strobe width", we_low, WP_CYC);
      check(dq_oe && !ce_n && dq_o == fall_data && mem_addr == fall_addr,
            "R3 hold/stable", int'(dq_o), int'(fall_data));
      wr_addr = mem_addr;
      wr_data = dq_o;
      busy_left = busy_len;
      we_low = 0;
    end
    prev_we = we_n;
    prev_oe = oe_n;
    prev_dq_oe = dq_oe;
    if (busy_left > 0 && mem_addr == wr_addr && !poll_lie)
      truth = {~wr_data[7], wr_data[6:0]};
    else if (busy_left > 0 && mem_addr == wr_addr)
      truth = wr_data;
    else
      truth = mem_rd(int'(mem_addr));
    dq_i = (age >= ACC_CYC) ? truth : ~truth;
    rdy  = (busy_left == 0) && !rdy_stuck_low;
  end

  // issue one command at a falling edge, wait for its response
  task automatic do_req(input logic wr, input logic md, input logic [12:0] a,
                        input logic [7:0] d, output logic [7:0] rd,
                        output logic er, output int lat);
    bit ready_seen = 0;
    int n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; mode_rdy = md;
    @(negedge clk);
    req_valid = 1'b0; mode_rdy = ~md;  // R9: mode must be latched at acceptance
    req_addr = ~a; req_wdata = ~d;
    lat = 1;
    while (!rsp_valid && n < 5000) begin
      if (req_ready) ready_seen = 1;
      @(negedge clk);
      lat++; n++;
    end
    check(rsp_valid, "R8 response seen", rsp_valid, 1);
    check(!ready_seen, "R6 ready low while busy", ready_seen, 0);
    rd = rsp_rdata;
    er = rsp_err;
    @(negedge clk);
    check(!rsp_valid, "R8 one-cycle pulse", rsp_valid, 0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [7:0] rd;
    logic er;
    int lat;
    repeat (3) @(negedge clk);
    check(ce_n && oe_n && we_n && !dq_oe && req_ready && !rsp_valid,
          "R10 reset state", {ce_n, oe_n, we_n, dq_oe, req_ready, rsp_valid}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && ce_n, "R10 idle after reset", {req_ready, ce_n}, 2'b11);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VEC[i];
      poll_reads = 0;
      do_req(v[31], v[30], v[28:16], v[15:8], rd, er, lat);
      if (v[31]) begin
        check(er == 1'b0 && rd == 8'h00, "R8 write response", {er, rd}, 0);
        if (v[30]) check(poll_reads == 0, "R5 no reads in ready/busy mode", poll_reads, 0);
        else       check(poll_reads >= 2, "R4 repeated poll reads", poll_reads, 2);
        check(lat > BUSY_NORM, "R4/R5 waited for write end", lat, BUSY_NORM);
      end else begin
        check(rd == v[7:0], "R1 read data", rd, v[7:0]);
        check(er == 1'b0, "R8 read err", er, 0);
        check(lat >= ACC_CYC + DF_CYC, "R1 read duration", lat, ACC_CYC + DF_CYC);
      end
    end

    // R5: ready/busy mode ignores bit 7 even if it looks complete
    poll_lie = 1'b1;
    do_req(1'b1, 1'b1, 13'h0222, 8'h5A, rd, er, lat);
    check(lat > BUSY_NORM && !er, "R5 waits for ready line", lat, BUSY_NORM);
    poll_lie = 1'b0;

    // R4: polling mode ignores a ready line stuck low
    rdy_stuck_low = 1'b1;
    poll_reads = 0;
    do_req(1'b1, 1'b0, 13'h0333, 8'hC3, rd, er, lat);
    check(!er && lat < TO_CYC, "R4 polling ignores ready line", {er, 16'(lat)}, 0);
    do_req(1'b0, 1'b0, 13'h0333, 8'h00, rd, er, lat);
    check(rd == 8'hC3, "R1 read after poll write", rd, 8'hC3);

    // R7: ready/busy mode timeout
    do_req(1'b1, 1'b1, 13'h0444, 8'h11, rd, er, lat);
    check(er == 1'b1, "R7 ready/busy timeout err", er, 1);
    check(lat >= TO_CYC, "R7 timeout not early", lat, TO_CYC);
    rdy_stuck_low = 1'b0;
    repeat (BUSY_NORM + 4) @(negedge clk);

    // R7: polling mode timeout with a write that never ends
    busy_len = 1000000;
    do_req(1'b1, 1'b0, 13'h0555, 8'h99, rd, er, lat);
    check(er == 1'b1 && rd == 8'h00, "R7 polling timeout err", {er, rd}, 9'h100);
    check(lat >= TO_CYC, "R7 polling timeout not early", lat, TO_CYC);
    @(posedge clk);
    busy_left = 1;
    busy_len = BUSY_NORM;
    repeat (4) @(negedge clk);

    // R8: a read after a timed-out write reports no error
    do_req(1'b0, 1'b0, 13'h0555, 8'h00, rd, er, lat);
    check(rd == 8'h99 && !er, "R8 clean read after timeout", {er, rd}, 9'h099);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule